// File: doc/BRIEF.md
# Level-Sensitive Two-Output Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and presents them to a processor as two interrupt output lines. Software controls the block through a small word-addressed register port. Each source has a mask bit. A mask bit is set through one write-one-to-set register and cleared through a separate write-one-to-clear register, so no read-modify-write is needed.

A routing register sends each unmasked source to output 0 or output 1. Software reads a masked pending word for each output and a raw view of the inputs. Mask bit 31 has two jobs. It is the mask of source 31, and it is also the master gate for both output lines.

Nothing is latched. A status bit and an output line follow their input levels in the same cycle. The bus port completes a write on the next clock edge. Read data is combinational from the presented address.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the mask word and the routing word are all zeros, the global gate is off, and both output lines are low whatever the inputs are.
- R2: A write to byte offset 0x34 sets every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. A read of 0x34 returns the current mask word.
- R3: A write to byte offset 0x38 clears every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged, so all ones clears the whole mask. A read of 0x38 returns zero.
- R4: The routing word is written and read at byte offset 0x20. A routing bit of 0 sends its source to output 0, and a routing bit of 1 sends it to output 1. Writing zero sends every source to output 0.
- R5: A read of offset 0x00 returns irq_in AND mask AND NOT routing. A read of offset 0x04 returns irq_in AND mask AND routing. Neither pending word depends on the global gate.
- R6: A read of offset 0x30 returns irq_in unmasked.
- R7: Mask bit 31 is the global gate. irq_out0 is high exactly when the gate is set and the output-0 pending word is non-zero, and irq_out1 behaves the same way with the output-1 word. When the gate is clear, both lines stay low.
- R8: Sources are level-sensitive and not latched. When an input drops, its pending bit and any output it alone drove fall in that same cycle, with no clear write needed.
- R9: Writes to offsets 0x00, 0x04, 0x30 or to any unmapped offset change no state. Reads of unmapped offsets, for example 0x10, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_in | input | 32 | Level interrupt request lines |
| irq_out0 | output | 1 | Interrupt line for sources routed to 0 |
| irq_out1 | output | 1 | Interrupt line for sources routed to 1 |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, a 6-bit address and the global gate at bit 31. With these values the real offsets are exercised, and bit 31 is tested both as the mask of source 31 and as the master gate. A table of input patterns is run against one fixed mask and routing setup, which covers split routing, masked-off sources and all inputs high. Directed tests then cover cumulative set, clear-all, gate-off with pending sources, input release, and writes to read-only and unmapped offsets.

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6,
  parameter int GLOBAL_BIT = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] irq_in,
  output logic              irq_out0,
  output logic              irq_out1
);

  localparam logic [ADDR_W-1:0] OFS_PEND0 = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_PEND1 = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_ROUTE = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFS_RAW   = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] OFS_SET   = ADDR_W'('h34);
  localparam logic [ADDR_W-1:0] OFS_CLR   = ADDR_W'('h38);

  logic [DATA_W-1:0] mask_q, route_q, pend0, pend1;
  logic              wr, gate;

  assign wr    = bus_sel & bus_we;
  assign pend0 = irq_in & mask_q & ~route_q;
  assign pend1 = irq_in & mask_q & route_q;
  assign gate  = mask_q[GLOBAL_BIT];

  assign irq_out0 = gate & (|pend0);
  assign irq_out1 = gate & (|pend1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_SET:   mask_q  <= mask_q | bus_wdata;
        OFS_CLR:   mask_q  <= mask_q & ~bus_wdata;
        OFS_ROUTE: route_q <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_PEND0: bus_rdata = pend0;
      OFS_PEND1: bus_rdata = pend1;
      OFS_ROUTE: bus_rdata = route_q;
      OFS_RAW:   bus_rdata = irq_in;
      OFS_SET:   bus_rdata = mask_q;
      default:   bus_rdata = '0;
    endcase
  end

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_SET) |=> mask_q == ($past(mask_q) | $past(bus_wdata)));

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_CLR) |=> mask_q == ($past(mask_q) & ~$past(bus_wdata)));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (bus_addr == OFS_SET || bus_addr == OFS_CLR)) |=> $stable(mask_q));

  // R4
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == OFS_ROUTE) |=> $stable(route_q));

  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[GLOBAL_BIT] |-> (!irq_out0 && !irq_out1));

  // R8
  out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out0 || irq_out1) |-> (irq_in & mask_q) != '0);

endmodule

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, irq_in;
  logic        irq_out0, irq_out1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lvl_irq_ctrl u_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out0(irq_out0), .irq_out1(irq_out1));

  localparam int NV = 8;
  localparam logic [31:0] V_IN [NV] = '{32'h0, 32'h1, 32'h100, 32'hF0,
                                        32'hFFFF_FFFF, 32'h8000_0000, 32'hF000, 32'hA05};
  localparam logic [31:0] V_P0 [NV] = '{32'h0, 32'h1, 32'h0, 32'h0,
                                        32'h8000_000F, 32'h8000_0000, 32'h0, 32'h5};
  localparam logic [31:0] V_P1 [NV] = '{32'h0, 32'h0, 32'h100, 32'h0,
                                        32'h0000_0F00, 32'h0, 32'h0, 32'hA00};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic outs(input string req, input logic e0, input logic e1);
    #1;
    chk(req, {30'b0, irq_out1, irq_out0}, {30'b0, e1, e0});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; irq_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(6'h34, d); chk("R1 mask", d, 32'h0);
    rd(6'h20, d); chk("R1 route", d, 32'h0);
    outs("R1 outputs", 1'b0, 1'b0);
    // R6 raw view
    rd(6'h30, d); chk("R6 raw", d, 32'hFFFF_FFFF);

    // table setup: mask 0x80000F0F, route 0x0000FF00
    wr(6'h20, 32'h0000_FF00);
    wr(6'h34, 32'h8000_0F0F);
    rd(6'h20, d); chk("R4 route readback", d, 32'h0000_FF00);
    rd(6'h34, d); chk("R2 mask readback", d, 32'h8000_0F0F);
    rd(6'h38, d); chk("R3 clear reads zero", d, 32'h0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      irq_in = V_IN[i];
      rd(6'h00, d); chk("R5 pend0", d, V_P0[i]);
      rd(6'h04, d); chk("R5 pend1", d, V_P1[i]);
      rd(6'h30, d); chk("R6 raw", d, V_IN[i]);
      outs("R7 outputs", V_P0[i] != 0, V_P1[i] != 0);
    end

    // R8 release of input, same cycle, no clear
    @(negedge clk); irq_in = 32'h0000_0101;
    outs("R8 both asserted", 1'b1, 1'b1);
    @(negedge clk); irq_in = 32'h0000_0100;
    rd(6'h00, d); chk("R8 pend0 drops", d, 32'h0);
    outs("R8 out0 drops", 1'b0, 1'b1);

    // R9 writes to read-only / unmapped offsets
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h30, 32'h0);
    rd(6'h34, d); chk("R9 mask unchanged", d, 32'h8000_0F0F);
    rd(6'h20, d); chk("R9 route unchanged", d, 32'h0000_FF00);
    rd(6'h10, d); chk("R9 unmapped reads zero", d, 32'h0);

    // R3 partial clear, then clear all
    wr(6'h38, 32'h0000_0F00);
    rd(6'h34, d); chk("R3 partial clear", d, 32'h8000_000F);
    outs("R3 masked out1", 1'b0, 1'b0);
    wr(6'h38, 32'hFFFF_FFFF);
    rd(6'h34, d); chk("R3 clear all", d, 32'h0);

    // R2 cumulative set
    wr(6'h34, 32'h1);
    wr(6'h34, 32'h2);
    rd(6'h34, d); chk("R2 cumulative set", d, 32'h3);

    // R7 gate off with pending sources
    wr(6'h20, 32'h0);
    wr(6'h34, 32'h7FFF_FFFF);
    @(negedge clk); irq_in = 32'hFFFF_FFFF;
    rd(6'h00, d); chk("R5 pend0 gate off", d, 32'h7FFF_FFFF);
    rd(6'h04, d); chk("R4 all to out0", d, 32'h0);
    outs("R7 gate off", 1'b0, 1'b0);
    wr(6'h34, 32'h8000_0000);
    outs("R7 gate on", 1'b1, 1'b0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule